// File: doc/BRIEF.md
# Password-Guarded Reset Controller

This block sits on a simple word-addressed register bus and arbitrates reset requests for a processor, its peripherals and a shared active-low board reset line. Software asks for any mix of a processor reset, a peripheral reset and a board-line pulse by writing one command word. The request counts only when the top byte of that word carries the password 0xA5. The mode word, which sets the user-reset enable, the interrupt enable and the board pulse length, is guarded by the same password.

The board line is sampled through a synchronizer. Every high-to-low transition sets a sticky flag that is cleared by reading the status word. While user reset is enabled, a low level on the line holds the processor and peripherals in reset. While it is disabled, the sticky flag can instead raise an interrupt. The controller flags itself busy for as long as a software-requested pulse is running, and it rejects new commands during that time. The status word also reports the kind of the most recent reset.

Top module: `keyed_reset_ctrl`

## Requirements
- R1: After reset, status reads 0x00010000 while the line is high: busy clear, sticky clear, kind 0 for power-up. The mode word reads 0x00000001, so user reset is enabled. Command reads return 0, and all reset outputs and the interrupt are inactive.
- R2: Words sit at offsets 0x0 (command), 0x4 (status) and 0x8 (mode). In the mode word, bit 0 is user-reset enable, bit 4 is interrupt enable and bits 11:8 are the board pulse length. A key-correct mode write reads back with all other bits zero.
- R3: A command or mode write whose bits 31:24 differ from 0xA5 changes nothing.
- R4: An accepted command with bit 0 set drives `proc_rst` high, and one with bit 2 set drives `periph_rst` high. The pulse lasts INT_PULSE cycles, starting the cycle after the write. Status bits 10:8 then read 3 (software).
- R5: An accepted command with bit 3 set drives `pin_drive_n` low for 2^(length+1) cycles, starting the cycle after the write.
- R6: Status bit 17 is 1 from the accepting edge until every pulse of the command has ended. A command written while it is 1 is ignored.
- R7: Status bit 0 becomes 1 after any falling edge of the synchronized line and is cleared by a status read. If a read and a detected edge fall in the same cycle, the bit stays 1.
- R8: Status bit 16 shows the line level after a two-flop synchronizer, so a change appears two edges after it happens.
- R9: With user reset enabled, a synchronized low on the line that the block is not driving itself holds `proc_rst` and `periph_rst` high, and its falling edge sets the kind to 4 (user). With user reset disabled, the line causes no reset.
- R10: `irq` is 1 exactly when the sticky bit is 1, the interrupt enable is 1 and user reset is disabled.
- R11: A key-correct command word with bits 0, 2 and 3 all zero starts nothing and leaves the kind unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe; a status read clears the sticky bit |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, valid while it is addressed |
| pin_in_n | input | 1 | Sensed level of the board reset line |
| pin_drive_n | output | 1 | Pulls the board line low when 0 |
| proc_rst | output | 1 | Processor reset request, active high |
| periph_rst | output | 1 | Peripheral reset request, active high |
| irq | output | 1 | User-reset interrupt, active high |

## Verification
The checker watches several rules on every cycle:
- The interrupt never coexists with user reset enabled.
- The board line is never driven without the busy flag.
- A detected falling edge always leaves the sticky bit set.
- A wrong-key command from idle never makes the block busy.
- An accepted command always reports busy with kind 3.

The bench scenarios show what spans many cycles or depends on history:
- The exact length of each pulse.
- The two-edge delay of the line level.
- That commands written while busy are ignored.
- That the block does not treat its own board pulse as a user reset.
- The race between a status read and a newly detected edge.

// File: rtl/krc_pkg.sv
// Shared constants and types for the password-guarded reset controller.
// Assumes a 32-bit data bus; offsets and field positions are fixed by the map.
package krc_pkg;
    localparam logic [7:0] PASS_KEY  = 8'hA5;
    localparam int         OFS_CMD   = 0;
    localparam int         OFS_STAT  = 4;
    localparam int         OFS_MODE  = 8;
    localparam int         KEY_LSB   = 24;
    localparam int         LEN_LSB   = 8;
    localparam int         UEN_BIT   = 0;
    localparam int         IEN_BIT   = 4;
    localparam int         PROC_BIT  = 0;
    localparam int         PERI_BIT  = 2;
    localparam int         EXT_BIT   = 3;
    localparam int         STICKY_BIT = 0;
    localparam int         KIND_LSB  = 8;
    localparam int         LEVEL_BIT = 16;
    localparam int         BUSY_BIT  = 17;

    typedef enum logic [2:0] {
        KIND_POWER = 3'd0,
        KIND_WDOG  = 3'd2,
        KIND_SOFT  = 3'd3,
        KIND_USER  = 3'd4
    } rst_kind_e;

    typedef struct packed {
        logic ext;
        logic periph;
        logic proc;
    } sw_cmd_t;
endpackage

// File: rtl/krc_pin_sync.sv
// Synchronizes the board reset line, flags its falling edges and delays
// the block's own drive by the same depth so both line up in time.
// Assumes STAGES >= 2 and that the line idles high.
module krc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic own_drive,
    output logic level,
    output logic fall,
    output logic own_aligned
);
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] own_q;
    logic              last_q;

    // Shift the raw line and the own-drive flag through matching chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            own_q  <= '0;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_n};
            own_q  <= {own_q[STAGES-2:0], own_drive};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign level       = sync_q[STAGES-1];
    assign fall        = last_q & ~sync_q[STAGES-1];
    assign own_aligned = own_q[STAGES-1];
endmodule

// File: rtl/krc_cmd_engine.sv
// Accepts a software reset command when idle and times its pulses: a fixed
// internal pulse for processor/peripheral and 2^(len+1) cycles on the line.
// Assumes start is already qualified by the password.
module krc_cmd_engine
    import krc_pkg::*;
#(
    parameter int INT_PULSE = 8,
    parameter int LEN_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  sw_cmd_t          cmd,
    input  logic [LEN_W-1:0] len,
    output logic             accept,
    output logic             busy,
    output logic             proc_pulse,
    output logic             periph_pulse,
    output logic             drive_n
);
    localparam int CNT_W = (1 << LEN_W) + 1;
    localparam int INT_W = $clog2(INT_PULSE + 1);

    logic [INT_W-1:0] int_cnt;
    logic [CNT_W-1:0] ext_cnt;
    logic             sel_proc;
    logic             sel_periph;

    // Busy while either pulse counter still runs.
    assign busy   = (int_cnt != '0) || (ext_cnt != '0);
    // Only an idle engine with at least one request bit takes a command.
    assign accept = start && !busy && (cmd.proc || cmd.periph || cmd.ext);

    // Load counters on acceptance, otherwise count them down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_cnt    <= '0;
            ext_cnt    <= '0;
            sel_proc   <= 1'b0;
            sel_periph <= 1'b0;
        end else if (accept) begin
            int_cnt    <= (cmd.proc || cmd.periph) ? INT_W'(INT_PULSE) : '0;
            ext_cnt    <= cmd.ext ? (CNT_W'(1) << (32'(len) + 32'd1)) : '0;
            sel_proc   <= cmd.proc;
            sel_periph <= cmd.periph;
        end else begin
            if (int_cnt != '0) int_cnt <= int_cnt - 1'b1;
            if (ext_cnt != '0) ext_cnt <= ext_cnt - 1'b1;
        end
    end

    assign proc_pulse   = sel_proc && (int_cnt != '0);
    assign periph_pulse = sel_periph && (int_cnt != '0);
    assign drive_n      = (ext_cnt == '0);
endmodule

// File: rtl/keyed_reset_ctrl.sv
// Top of the password-guarded reset controller: register decode, mode and
// status state, user-reset and interrupt logic.
// Assumes single-cycle bus strobes and combinational read data.
module keyed_reset_ctrl
    import krc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int INT_PULSE = 8,
    parameter int LEN_W     = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pin_in_n,
    output logic              pin_drive_n,
    output logic              proc_rst,
    output logic              periph_rst,
    output logic              irq
);
    logic             key_ok, wr_cmd, wr_mode, rd_stat;
    logic             urst_en, irq_en;
    logic [LEN_W-1:0] ext_len;
    logic             sticky;
    rst_kind_e        rst_kind;
    logic             accept, busy, proc_pulse, periph_pulse;
    logic             level, fall, own_aligned, user_rst;
    sw_cmd_t          cmd;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[23:12], bus_wdata[7:5], bus_wdata[1]};

    // Decode guarded writes and the clearing status read.
    assign key_ok  = (bus_wdata[KEY_LSB +: 8] == PASS_KEY);
    assign wr_cmd  = bus_wr && key_ok && (bus_addr == ADDR_W'(OFS_CMD));
    assign wr_mode = bus_wr && key_ok && (bus_addr == ADDR_W'(OFS_MODE));
    assign rd_stat = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));

    assign cmd.proc   = bus_wdata[PROC_BIT];
    assign cmd.periph = bus_wdata[PERI_BIT];
    assign cmd.ext    = bus_wdata[EXT_BIT];

    krc_cmd_engine #(
        .INT_PULSE (INT_PULSE),
        .LEN_W     (LEN_W)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (wr_cmd),
        .cmd          (cmd),
        .len          (ext_len),
        .accept       (accept),
        .busy         (busy),
        .proc_pulse   (proc_pulse),
        .periph_pulse (periph_pulse),
        .drive_n      (pin_drive_n)
    );

    krc_pin_sync #(
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_n       (pin_in_n),
        .own_drive   (~pin_drive_n),
        .level       (level),
        .fall        (fall),
        .own_aligned (own_aligned)
    );

    // Hold the mode fields; user reset is enabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            urst_en <= 1'b1;
            irq_en  <= 1'b0;
            ext_len <= '0;
        end else if (wr_mode) begin
            urst_en <= bus_wdata[UEN_BIT];
            irq_en  <= bus_wdata[IEN_BIT];
            ext_len <= bus_wdata[LEN_LSB +: LEN_W];
        end
    end

    // Sticky edge flag: an edge wins over a clearing read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       sticky <= 1'b0;
        else if (fall)    sticky <= 1'b1;
        else if (rd_stat) sticky <= 1'b0;
    end

    // A low line the block is not driving itself counts as a user reset.
    assign user_rst = urst_en && !level && !own_aligned;

    // Record the kind of the latest reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rst_kind <= KIND_POWER;
        else if (accept)                           rst_kind <= KIND_SOFT;
        else if (fall && urst_en && !own_aligned)  rst_kind <= KIND_USER;
    end

    assign proc_rst   = proc_pulse || user_rst;
    assign periph_rst = periph_pulse || user_rst;
    assign irq        = sticky && irq_en && !urst_en;

    // Read mux for the addressed word.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_STAT)) begin
            bus_rdata[STICKY_BIT]       = sticky;
            bus_rdata[KIND_LSB +: 3]    = rst_kind;
            bus_rdata[LEVEL_BIT]        = level;
            bus_rdata[BUSY_BIT]         = busy;
        end else if (bus_addr == ADDR_W'(OFS_MODE)) begin
            bus_rdata[UEN_BIT]          = urst_en;
            bus_rdata[IEN_BIT]          = irq_en;
            bus_rdata[LEN_LSB +: LEN_W] = ext_len;
        end
    end
endmodule

// File: rtl/krc_checker.sv
// Cycle-by-cycle rules for the reset controller, bound to its top.
// Assumes command offset 0 and password 0xA5.
module krc_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              busy,
    input logic [2:0]        rst_kind,
    input logic              irq,
    input logic              urst_en,
    input logic              pin_drive_n,
    input logic              fall,
    input logic              sticky
);
    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !urst_en);

    // R6
    drive_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_drive_n |-> busy);

    // R7
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> sticky);

    // R3
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && bus_wdata[31:24] != 8'hA5 && !busy) |=> !busy);

    // R4
    accept_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && bus_wdata[31:24] == 8'hA5 && !busy &&
         (bus_wdata[0] || bus_wdata[2] || bus_wdata[3])) |=> (busy && rst_kind == 3'd3));
endmodule

bind keyed_reset_ctrl krc_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .busy        (busy),
    .rst_kind    (rst_kind),
    .irq         (irq),
    .urst_en     (urst_en),
    .pin_drive_n (pin_drive_n),
    .fall        (fall),
    .sticky      (sticky)
);

// File: tb/tb_keyed_reset_ctrl.sv
// Scoreboard bench: driver tasks queue expected items, a monitor at the
// falling clock edge pops and compares them with the design's outputs.
module tb_keyed_reset_ctrl;
    localparam int INTP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bench_pin = 1'b1;
    logic        pin_in_n, pin_drive_n, proc_rst, periph_rst, irq;
    int          checks = 0, fails = 0;
    bit          done = 0;

    typedef struct {
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    assign pin_in_n = pin_drive_n & bench_pin;

    keyed_reset_ctrl #(.INT_PULSE(INTP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in_n(pin_in_n), .pin_drive_n(pin_drive_n), .proc_rst(proc_rst),
        .periph_rst(periph_rst), .irq(irq)
    );

    // Monitor: compare every queued item at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_rd ? bus_rdata : {28'b0, irq, proc_rst, periph_rst, pin_drive_n};
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        q.push_back('{1'b1, e, tag});
    endtask

    // Expected {irq, proc_rst, periph_rst, pin_drive_n}.
    task automatic sig_chk(input logic [3:0] e, input string tag);
        q.push_back('{1'b0, {28'b0, e}, tag});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        sig_chk(4'b0001, "R1 outputs");
        rd_chk(4'h4, 32'h0001_0000, "R1 status"); step();
        rd_chk(4'h8, 32'h0000_0001, "R1 mode"); step();
        rd_chk(4'h0, 32'h0, "R2 command reads zero"); step();

        // R3 wrong key ignored for command and mode
        wr(4'h0, 32'h5A00_0001);
        sig_chk(4'b0001, "R3 bad-key command");
        rd_chk(4'h4, 32'h0001_0000, "R3 not busy"); step();
        wr(4'h8, 32'h5A00_0010);
        rd_chk(4'h8, 32'h0000_0001, "R3 bad-key mode"); step();

        // R11 key-correct word with no request bits
        wr(4'h0, 32'hA500_0000);
        sig_chk(4'b0001, "R11 outputs");
        rd_chk(4'h4, 32'h0001_0000, "R11 idle, kind kept"); step();

        // R4 processor pulse, R6 busy during it
        wr(4'h0, 32'hA500_0001);
        sig_chk(4'b0101, "R4 proc pulse start");
        rd_chk(4'h4, 32'h0003_0300, "R6 busy and kind soft");
        for (int i = 1; i < INTP; i++) begin
            step();
            sig_chk(4'b0101, "R4 proc pulse held");
        end
        step();
        sig_chk(4'b0001, "R4 proc pulse end");
        rd_chk(4'h4, 32'h0001_0300, "R6 busy cleared"); step();

        // R4 peripheral pulse
        wr(4'h0, 32'hA500_0004);
        sig_chk(4'b0011, "R4 periph pulse start");
        repeat (INTP - 1) step();
        sig_chk(4'b0011, "R4 periph last cycle");
        step();
        sig_chk(4'b0001, "R4 periph pulse end");

        // R2 mode fields, R5 line pulse of 2^(1+1) cycles
        wr(4'h8, 32'hA500_0101);
        rd_chk(4'h8, 32'h0000_0101, "R2 mode readback"); step();
        wr(4'h0, 32'hA500_0008);
        sig_chk(4'b0000, "R5 line low");
        bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'hA500_0001;
        step();
        sig_chk(4'b0000, "R6 command while busy ignored");
        rd_chk(4'h4, 32'h0003_0300, "R6 busy during line pulse");
        step(); sig_chk(4'b0000, "R5 line low 3");
        step(); sig_chk(4'b0000, "R5 line low 4");
        step(); sig_chk(4'b0001, "R5 line released");
        step(); sig_chk(4'b0001, "R9 own pulse no user reset");
        step(); sig_chk(4'b0001, "R9 own pulse no user reset");
        step();
        rd_chk(4'h4, 32'h0001_0301, "R7 own edge sticky, R9 kind stays soft"); step();
        rd_chk(4'h4, 32'h0001_0300, "R7 cleared by read"); step();

        // R9 user reset from the line
        wr(4'h8, 32'hA500_0001);
        bench_pin = 1'b0;
        step(); sig_chk(4'b0001, "R8 one edge, no reset yet");
        step(); sig_chk(4'b0111, "R9 user reset active");
        step();
        rd_chk(4'h4, 32'h0000_0401, "R9 kind user"); step();
        bench_pin = 1'b1;
        step(); step();
        sig_chk(4'b0001, "R9 user reset released");
        rd_chk(4'h4, 32'h0001_0400, "R7 cleared after user reset"); step();

        // R10 interrupt with user reset disabled, R7 read/edge race
        wr(4'h8, 32'hA500_0010);
        rd_chk(4'h8, 32'h0000_0010, "R2 irq enable field"); step();
        bench_pin = 1'b0;
        step();
        rd_chk(4'h4, 32'h0001_0400, "R8 level still high after one edge");
        step();
        sig_chk(4'b0001, "R9 disabled, no reset");
        rd_chk(4'h4, 32'h0000_0400, "R8 level low after two edges");
        step();
        sig_chk(4'b1001, "R10 irq raised");
        rd_chk(4'h4, 32'h0000_0401, "R7 edge kept over same-cycle read");
        step();
        sig_chk(4'b0001, "R10 irq cleared by read");
        bench_pin = 1'b1;
        repeat (3) step();

        // R10 interrupt masked while user reset is enabled
        wr(4'h8, 32'hA500_0011);
        bench_pin = 1'b0;
        repeat (3) step();
        sig_chk(4'b0111, "R10 no irq with user reset on");
        rd_chk(4'h4, 32'h0000_0401, "R10 sticky set but masked"); step();
        bench_pin = 1'b1;
        repeat (3) step();
        sig_chk(4'b0001, "R9 released");
        step();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule